// File: doc/BRIEF.md
# AES Column Mixing Unit (Forward and Inverse)

This block applies the AES column-mixing step, or its inverse, to a whole 128-bit cipher state in a single pass. The state is four 32-bit columns, and each column is transformed on its own. A mode bit selects the direction: encryption uses the forward matrix, decryption uses the inverse matrix. Both the mode and the state are captured when the input valid strobe is high.

No general GF(2^8) multiplier is used. The forward path doubles each input byte once (shift left, then reduce by 0x1B). Each tripled term is that doubled value XOR the original byte. The inverse path builds its constants from a few parts: the doubling units, a second doubling stage for ×4, and a ×8 unit. The ×8 unit shifts the byte left by three and XORs in a correction byte derived from the three bits that fall off the top.

The result is registered. A valid flag marks it one clock after the input strobe. The surrounding round logic (byte substitution, row rotation, key addition) lives elsewhere.

Top module: `mixcol_unit`

## Requirements
- R1: In forward mode (in_inverse = 0), each output column holds the four bytes {2a^3b^c^d, a^2b^3c^d, a^b^2c^3d, 3a^b^c^2d}, where a..d are the input column's bytes from row 0 to row 3. For example, column db 13 53 45 gives 8e 4d a1 bc.
- R2: Doubling a byte whose bit 7 is set reduces the result by 0x1B. For example, forward column f2 0a 22 5c gives 9f dc 58 9d.
- R3: In inverse mode (in_inverse = 1), each column is multiplied by the circulant matrix whose rows, from top to bottom, are {0e 0b 0d 09}, {09 0e 0b 0d}, {0d 09 0e 0b} and {0b 0d 09 0e}. For example, inverse column 8e 4d a1 bc gives db 13 53 45.
- R4: The ×8 product folds the top three input bits back into the byte correctly, including when all three are set. For example, inverse column 9f dc 58 9d gives f2 0a 22 5c, and inverse column ff ff ff ff gives ff ff ff ff.
- R5: Column 0 occupies bits [127:96] and column 3 occupies bits [31:0]. Row 0 is the most significant byte of each column. Columns do not affect each other.
- R6: The mode bit is sampled in the same cycle as the state. Inputs that arrive back to back with alternating modes each produce the result for their own mode.
- R7: When in_valid is high on a clock edge, out_state holds the result and out_valid is 1 after that edge. When in_valid is low on a clock edge, out_valid is 0 after that edge.
- R8: While in_valid is low, out_state keeps its value whatever in_state and in_inverse do.
- R9: A synchronous active-high reset clears out_valid, and reset takes precedence over a simultaneous in_valid.
- R10: Applying the forward transform and then the inverse transform returns the original state for any input.
- R11: In both modes, the XOR of the four output bytes of a column equals the XOR of its four input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Captures in_state and in_inverse |
| in_inverse | input | 1 | 0 = forward, 1 = inverse |
| in_state | input | 128 | State to transform, column 0 in the top 32 bits |
| out_valid | output | 1 | out_state was loaded on the previous edge |
| out_state | output | 128 | Registered transformed state |

## Verification
Two events can land on the same edge: a reset and an input strobe. The bench raises both together. It then checks that out_valid stays low, and that the next strobe after reset produces a fresh result.

A second collision happens on back-to-back strobes, where one input's result appears in the same cycle as the next input with the opposite mode is captured. Each of those results is compared against a bench model built from a bitwise GF(2^8) multiply.

// File: rtl/mixcol_unit.sv
module mixcol_unit #(
  parameter int NCOL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_inverse,
  input  logic [32*NCOL-1:0] in_state,
  output logic              out_valid,
  output logic [32*NCOL-1:0] out_state
);
  localparam int W = 32 * NCOL;

  function automatic logic [7:0] dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] oct(input logic [7:0] b);
    logic [7:0] t;
    t = {1'b0, b[7], b[6] ^ b[7], b[5] ^ b[6], b[5] ^ b[7],
         b[6] ^ b[7], b[5] ^ b[6], b[5]};
    return {b[4:0], 3'b000} ^ t;
  endfunction

  logic [W-1:0] fwd, inv;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int B = W - 32 * (c + 1);
    logic [7:0] s [4];
    logic [7:0] d [4];
    logic [7:0] q [4];
    logic [7:0] e [4];
    logic [7:0] m9 [4], mb [4], md [4], me [4];

    for (genvar r = 0; r < 4; r++) begin : g_byte
      assign s[r]  = in_state[B + 8*(3-r) +: 8];
      assign d[r]  = dbl(s[r]);
      assign q[r]  = dbl(d[r]);
      assign e[r]  = oct(s[r]);
      assign m9[r] = e[r] ^ s[r];
      assign mb[r] = e[r] ^ d[r] ^ s[r];
      assign md[r] = e[r] ^ q[r] ^ s[r];
      assign me[r] = e[r] ^ q[r] ^ d[r];
    end

    assign fwd[B+24 +: 8] = d[0] ^ d[1] ^ s[1] ^ s[2] ^ s[3];
    assign fwd[B+16 +: 8] = s[0] ^ d[1] ^ d[2] ^ s[2] ^ s[3];
    assign fwd[B+8  +: 8] = s[0] ^ s[1] ^ d[2] ^ d[3] ^ s[3];
    assign fwd[B    +: 8] = d[0] ^ s[0] ^ s[1] ^ s[2] ^ d[3];

    assign inv[B+24 +: 8] = me[0] ^ mb[1] ^ md[2] ^ m9[3];
    assign inv[B+16 +: 8] = m9[0] ^ me[1] ^ mb[2] ^ md[3];
    assign inv[B+8  +: 8] = md[0] ^ m9[1] ^ me[2] ^ mb[3];
    assign inv[B    +: 8] = mb[0] ^ md[1] ^ m9[2] ^ me[3];

    assert_col_parity_R11: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ((out_state[B+24 +: 8] ^ out_state[B+16 +: 8] ^
                     out_state[B+8 +: 8] ^ out_state[B +: 8]) ==
                    ($past(in_state[B+24 +: 8]) ^ $past(in_state[B+16 +: 8]) ^
                     $past(in_state[B+8 +: 8]) ^ $past(in_state[B +: 8]))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
    if (in_valid && !rst) out_state <= in_inverse ? inv : fwd;
  end

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_state));
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/sim_mixcol_unit.sv
module sim_mixcol_unit;
  logic clk = 0, rst = 1, in_valid = 0, in_inverse = 0;
  logic [127:0] in_state = '0;
  logic out_valid;
  logic [127:0] out_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mixcol_unit #(.NCOL(4)) u0 (.clk, .rst, .in_valid, .in_inverse, .in_state,
                              .out_valid, .out_state);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1b) : {x[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_mix(input logic [127:0] st, input bit inv);
    logic [7:0] k [4];
    logic [127:0] r = '0;
    if (inv) k = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     k = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int row = 0; row < 4; row++) begin
        logic [7:0] acc = 0;
        for (int j = 0; j < 4; j++)
          acc ^= gmul(st[127 - 32*c - 8*j -: 8], k[(j - row + 4) % 4]);
        r[127 - 32*c - 8*row -: 8] = acc;
      end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] st, input bit inv);
    @(negedge clk);
    in_valid = 1; in_inverse = inv; in_state = st;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 0; in_state = ~st; in_inverse = ~inv;
  endtask

  task automatic t_reset;
    rst = 1; in_valid = 1; in_state = 128'h1;
    repeat (3) @(posedge clk);
    #1 chk(out_valid == 0, "R9 reset with in_valid", 128'(out_valid), 0);
    @(negedge clk); rst = 0; in_valid = 0;
  endtask

  task automatic t_forward;
    logic [127:0] v = {32'hdb135345, 32'hf20a225c, 32'h01010101, 32'hd4d4d4d5};
    apply(v, 0);
    chk(out_state == {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hd5d5d7d6},
        "R1 R2 R5 forward vectors", out_state,
        {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hd5d5d7d6});
    chk(out_valid == 1, "R7 valid after load", 128'(out_valid), 1);
    v = {32'h2d26314c, 32'hc6c6c6c6, 32'h00000000, 32'h80000000};
    apply(v, 0);
    chk(out_state == ref_mix(v, 0), "R1 R5 forward second pattern", out_state, ref_mix(v, 0));
  endtask

  task automatic t_inverse;
    logic [127:0] v = {32'h8e4da1bc, 32'h9fdc589d, 32'hffffffff, 32'he0e0e0e0};
    apply(v, 1);
    chk(out_state[127:64] == {32'hdb135345, 32'hf20a225c}, "R3 R4 inverse vectors",
        out_state, ref_mix(v, 1));
    chk(out_state[63:32] == 32'hffffffff, "R4 all top bits set", out_state, ref_mix(v, 1));
    chk(out_state == ref_mix(v, 1), "R3 R5 inverse full state", out_state, ref_mix(v, 1));
  endtask

  task automatic t_hold;
    logic [127:0] held;
    apply(128'h0123456789abcdeffedcba9876543210, 0);
    held = out_state;
    repeat (4) begin
      @(negedge clk); in_state = in_state + 128'h1111; in_inverse = ~in_inverse;
    end
    @(posedge clk); #1;
    chk(out_state == held, "R8 hold while idle", out_state, held);
    chk(out_valid == 0, "R7 valid low when idle", 128'(out_valid), 0);
  endtask

  task automatic t_b2b;
    logic [127:0] a = 128'h00112233445566778899aabbccddeeff;
    logic [127:0] b = 128'hfedcba98765432100f1e2d3c4b5a6978;
    @(negedge clk); in_valid = 1; in_inverse = 0; in_state = a;
    @(negedge clk);
    chk(out_state == ref_mix(a, 0) && out_valid, "R6 back-to-back forward", out_state, ref_mix(a, 0));
    in_inverse = 1; in_state = b;
    @(negedge clk);
    chk(out_state == ref_mix(b, 1) && out_valid, "R6 back-to-back inverse", out_state, ref_mix(b, 1));
    in_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_roundtrip;
    for (int n = 0; n < 40; n++) begin
      logic [127:0] v = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] f;
      apply(v, 0);
      f = out_state;
      chk(f == ref_mix(v, 0), "R1 random forward", f, ref_mix(v, 0));
      apply(f, 1);
      chk(out_state == v, "R10 round trip", out_state, v);
    end
  endtask

  task automatic t_reset_collide;
    @(negedge clk); rst = 1; in_valid = 1; in_state = 128'h5;
    @(posedge clk); #1;
    chk(out_valid == 0, "R9 reset beats in_valid", 128'(out_valid), 0);
    @(negedge clk); rst = 0; in_valid = 0;
    apply(128'hdb135345db135345db135345db135345, 0);
    chk(out_state == {4{32'h8e4da1bc}} && out_valid, "R9 fresh load after reset",
        out_state, {4{32'h8e4da1bc}});
  endtask

  initial begin
    t_reset;
    t_forward;
    t_inverse;
    t_hold;
    t_b2b;
    t_roundtrip;
    t_reset_collide;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule